// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit with 40-bit Accumulator

This block keeps one 40-bit signed running sum and adds products of two 32-bit operands into it. A request carries an operation code, a two-bit half selector and two operands. The multiplier operand is `src_a` and the multiplicand operand is `src_b`. The unit has five operations:
- a 16x16 multiply on a chosen half of each operand;
- a paired 16x16 multiply that adds two products at once;
- a 32x32 multiply whose product is cut to 40 bits before it is added;
- a load of the accumulator from two words;
- a read that leaves the accumulator unchanged.

The accumulator is always visible as two registered 32-bit words. The low word holds the low 32 bits. The high word holds the top 8 bits, sign-extended.

Most requests finish in one cycle. A 32x32 request whose multiplier does not fit in a signed 16-bit value takes two cycles. In the first cycle it forms a partial product, and in the second it adds the rest. During the first cycle `busy` is high and new requests are ignored. The cycle after a request completes, `done` is high for one cycle.

Top module: `mac40_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `acc_lo` = 0, `acc_hi` = 0, `done` = 0 and `busy` = 0.
- R2: Op code 0 multiplies one signed 16-bit half of `src_a` by one signed 16-bit half of `src_b` and adds the product. `half_sel[1]` picks the `src_a` half and `half_sel[0]` picks the `src_b` half, where 1 means bits 31:16 and 0 means bits 15:0.
- R3: Every addend is sign-extended to 40 bits, and the sum wraps modulo 2^40. For example, 0x7F_FFFF_FFFF plus 1 gives 0x80_0000_0000.
- R4: Op code 1 adds two signed products: high half times high half, and low half times low half.
- R5: Op code 2 forms the signed 64-bit product of `src_a` and `src_b` and adds only its low 40 bits.
- R6: Op codes 0 and 1 complete in one cycle. So does op code 2 when `src_a` lies in -32768..32767. In each case, `done` is 1 and `busy` is 0 in the cycle after acceptance, and the outputs already show the new sum.
- R7: Op code 2 with `src_a` outside -32768..32767 shows `busy` = 1 and `done` = 0 in the cycle after acceptance. In the cycle after that it shows `busy` = 0, `done` = 1 and the updated sum.
- R8: A request presented while `busy` is 1 is ignored: it changes neither the accumulator nor `done`.
- R9: Op code 3 loads the accumulator. Bits 31:0 come from `src_a` and bits 39:32 come from `src_b[7:0]`. `done` follows one cycle later.
- R10: `acc_lo` always shows accumulator bits 31:0, and `acc_hi` shows bits 39:32 sign-extended to 32 bits. Op code 4 (read) raises `done` one cycle later and leaves both words unchanged.
- R11: Op codes 5 to 7, and cycles with `in_valid` low, leave the accumulator unchanged. Reserved codes still raise `done`. An idle cycle does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 3 | Operation code |
| half_sel | input | 2 | Operand half choice for op code 0 |
| src_a | input | 32 | Multiplier operand, or low load word |
| src_b | input | 32 | Multiplicand operand, or high load word |
| done | output | 1 | Request completed (one-cycle pulse) |
| busy | output | 1 | Second step of a split multiply pending |
| acc_lo | output | 32 | Accumulator bits 31:0 |
| acc_hi | output | 32 | Accumulator bits 39:32, sign-extended |

## Verification
The risky overlap is the final add of a split 32x32 multiply landing in the same cycle as a newly presented request.

The bench starts a wide multiply with a large multiplier. During the `busy` cycle it drives a valid load request with distinctive operands.

The check passes only if three things hold:
- the sum afterwards equals the old sum plus the 40-bit product;
- exactly one `done` pulse appears;
- nothing of the load leaks in.

// File: rtl/mac40_pkg.sv
package mac40_pkg;

  typedef enum logic [2:0] {
    OP_MAC_HALF = 3'd0,
    OP_MAC_DUAL = 3'd1,
    OP_MAC_WIDE = 3'd2,
    OP_ACC_LOAD = 3'd3,
    OP_ACC_READ = 3'd4
  } mac_op_t;

endpackage

// File: rtl/mac40_halfmul.sv
// Narrow product path: one selected 16x16 product, or the sum of two lane
// products in paired mode. Results come out already sign-extended to ACC_W.
module mac40_halfmul #(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [1:0]        half_sel,
  input  logic              dual,
  output logic [ACC_W-1:0]  addend
);

  localparam int LANES = 2;

  logic signed [ACC_W-1:0] lane_prod [LANES];

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      logic signed [HALF_W-1:0] x;
      logic signed [HALF_W-1:0] y;
      if (g == 0) begin : g_primary
        // Paired mode forces low x low; otherwise the selector decides.
        always_comb begin
          x = (half_sel[1] && !dual) ? opa[DATA_W-1:HALF_W] : opa[HALF_W-1:0];
          y = (half_sel[0] && !dual) ? opb[DATA_W-1:HALF_W] : opb[HALF_W-1:0];
        end
      end else begin : g_upper
        always_comb begin
          x = opa[DATA_W-1:HALF_W];
          y = opb[DATA_W-1:HALF_W];
        end
      end
      // Evaluated at ACC_W width, so the signed product is sign-extended.
      assign lane_prod[g] = x * y;
    end
  endgenerate

  always_comb begin
    addend = lane_prod[0];
    if (dual) addend = lane_prod[0] + lane_prod[1];
  end

endmodule

// File: rtl/mac40_widemul.sv
// 32x32 product path, truncated to ACC_W bits. A multiplier that fits in
// HALF_W signed bits gets a one-step product. Otherwise the product is split:
// step one registers (unsigned low half) * b, and step two adds
// (signed high half * b) shifted left by HALF_W.
module mac40_widemul #(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_split,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              fits_narrow,
  output logic [ACC_W-1:0]  quick_addend,
  output logic [ACC_W-1:0]  split_addend
);

  localparam int TOP_W = DATA_W - HALF_W + 1;

  logic [TOP_W-1:0]          top_bits;
  logic signed [HALF_W-1:0]  a_short;
  logic signed [DATA_W-1:0]  b_s;
  logic signed [HALF_W:0]    a_low_u;
  logic signed [ACC_W-1:0]   quick_p;
  logic signed [ACC_W-1:0]   low_p;

  logic [ACC_W-1:0]          part_q;
  logic signed [HALF_W-1:0]  a_high_q;
  logic signed [DATA_W-1:0]  b_q;
  logic signed [ACC_W-1:0]   high_p;

  assign top_bits    = opa[DATA_W-1:HALF_W-1];
  assign fits_narrow = (&top_bits) | ~(|top_bits);

  assign a_short = opa[HALF_W-1:0];
  assign b_s     = opb;
  assign quick_p = a_short * b_s;
  assign quick_addend = quick_p;

  assign a_low_u = {1'b0, opa[HALF_W-1:0]};
  assign low_p   = a_low_u * b_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      part_q   <= '0;
      a_high_q <= '0;
      b_q      <= '0;
    end else if (start_split) begin
      part_q   <= low_p;
      a_high_q <= opa[DATA_W-1:HALF_W];
      b_q      <= opb;
    end
  end

  assign high_p       = a_high_q * b_q;
  assign split_addend = part_q + (high_p <<< HALF_W);

endmodule

// File: rtl/mac40_acc.sv
// Accumulator register. A load takes precedence over an add.
module mac40_acc #(
  parameter int ACC_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add_en,
  input  logic [ACC_W-1:0] add_val,
  input  logic             load_en,
  input  logic [ACC_W-1:0] load_val,
  output logic [ACC_W-1:0] acc_q
);

  always_ff @(posedge clk) begin
    if (rst)          acc_q <= '0;
    else if (load_en) acc_q <= load_val;
    else if (add_en)  acc_q <= acc_q + add_val;
  end

endmodule

// File: rtl/mac40_unit.sv
module mac40_unit
  import mac40_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic [1:0]        half_sel,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              done,
  output logic              busy,
  output logic [DATA_W-1:0] acc_lo,
  output logic [DATA_W-1:0] acc_hi
);

  localparam int HI_W = ACC_W - DATA_W;

  logic             busy_q;
  logic             done_q;
  logic             accept;
  logic             start_split;
  logic             add_en;
  logic             load_en;
  logic [ACC_W-1:0] add_val;
  logic [ACC_W-1:0] load_val;
  logic [ACC_W-1:0] half_addend;
  logic [ACC_W-1:0] quick_addend;
  logic [ACC_W-1:0] split_addend;
  logic [ACC_W-1:0] acc_q;
  logic             fits_narrow;
  mac_op_t          opc;

  assign opc      = mac_op_t'(op);
  assign accept   = in_valid && !busy_q;
  assign load_val = {src_b[HI_W-1:0], src_a};

  mac40_halfmul #(.DATA_W(DATA_W), .HALF_W(HALF_W), .ACC_W(ACC_W)) u_half (
    .opa      (src_a),
    .opb      (src_b),
    .half_sel (half_sel),
    .dual     (opc == OP_MAC_DUAL),
    .addend   (half_addend)
  );

  mac40_widemul #(.DATA_W(DATA_W), .HALF_W(HALF_W), .ACC_W(ACC_W)) u_wide (
    .clk          (clk),
    .rst          (rst),
    .start_split  (start_split),
    .opa          (src_a),
    .opb          (src_b),
    .fits_narrow  (fits_narrow),
    .quick_addend (quick_addend),
    .split_addend (split_addend)
  );

  always_comb begin
    add_en      = 1'b0;
    add_val     = '0;
    load_en     = 1'b0;
    start_split = 1'b0;
    if (busy_q) begin
      add_en  = 1'b1;
      add_val = split_addend;
    end else if (accept) begin
      case (opc)
        OP_MAC_HALF, OP_MAC_DUAL: begin
          add_en  = 1'b1;
          add_val = half_addend;
        end
        OP_MAC_WIDE: begin
          if (fits_narrow) begin
            add_en  = 1'b1;
            add_val = quick_addend;
          end else begin
            start_split = 1'b1;
          end
        end
        OP_ACC_LOAD: load_en = 1'b1;
        default: ;
      endcase
    end
  end

  mac40_acc #(.ACC_W(ACC_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .add_en   (add_en),
    .add_val  (add_val),
    .load_en  (load_en),
    .load_val (load_val),
    .acc_q    (acc_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= start_split;
      done_q <= busy_q || (accept && !start_split);
    end
  end

  assign done   = done_q;
  assign busy   = busy_q;
  assign acc_lo = acc_q[DATA_W-1:0];
  assign acc_hi = {{(DATA_W-HI_W){acc_q[ACC_W-1]}}, acc_q[ACC_W-1:DATA_W]};

endmodule

// File: rtl/mac40_chk.sv
module mac40_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        op,
  input logic [DATA_W-1:0] src_a,
  input logic              done,
  input logic              busy,
  input logic [DATA_W-1:0] acc_lo,
  input logic [DATA_W-1:0] acc_hi
);

  logic small_mult;
  logic take;
  logic wide_req;

  assign small_mult = ($signed(src_a) >= -32768) && ($signed(src_a) <= 32767);
  assign take       = in_valid && !busy;
  assign wide_req   = (op == 3'd2);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (acc_lo == '0 && acc_hi == '0 && !done && !busy));

  // R6
  quick_done_chk: assert property (@(posedge clk) disable iff (rst)
    (take && !(wide_req && !small_mult)) |=> (done && !busy));

  // R7
  split_start_chk: assert property (@(posedge clk) disable iff (rst)
    (take && wide_req && !small_mult) |=> (busy && !done));

  // R7
  split_finish_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (done && !busy));

  // R10
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (take && op == 3'd4) |=> ($stable(acc_lo) && $stable(acc_hi)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !busy) |=> (!done && $stable(acc_lo) && $stable(acc_hi)));

endmodule

bind mac40_unit mac40_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .op       (op),
  .src_a    (src_a),
  .done     (done),
  .busy     (busy),
  .acc_lo   (acc_lo),
  .acc_hi   (acc_hi)
);

// File: tb/tb_mac40_unit.sv
`timescale 1ns/1ps
module tb_mac40_unit;

  localparam logic [2:0] C_HALF = 3'd0;
  localparam logic [2:0] C_DUAL = 3'd1;
  localparam logic [2:0] C_WIDE = 3'd2;
  localparam logic [2:0] C_LOAD = 3'd3;
  localparam logic [2:0] C_READ = 3'd4;
  localparam int NV = 13;

  // {op[2:0], half_sel[1:0], src_a[31:0], src_b[31:0]}
  localparam logic [68:0] VEC [NV] = '{
    {C_HALF, 2'b00, 32'h0003_0005, 32'h0007_FFFE},
    {C_HALF, 2'b11, 32'h8000_0001, 32'h8000_0000},
    {C_HALF, 2'b10, 32'hFFFF_0000, 32'h0000_0009},
    {C_HALF, 2'b01, 32'h0000_7FFF, 32'h7FFF_0000},
    {C_DUAL, 2'b00, 32'h0002_FFFD, 32'h0004_0005},
    {C_WIDE, 2'b00, 32'hFFFF_FFF0, 32'h1000_0000},
    {C_WIDE, 2'b00, 32'h7FFF_FFFF, 32'h7FFF_FFFF},
    {C_WIDE, 2'b00, 32'h8000_0000, 32'hFFFF_FFFF},
    {C_READ, 2'b00, 32'h1111_1111, 32'h2222_2222},
    {C_LOAD, 2'b00, 32'hDEAD_BEEF, 32'h1234_5680},
    {C_DUAL, 2'b00, 32'h8000_8000, 32'h8000_8000},
    {3'd7,   2'b11, 32'h5555_5555, 32'h5555_5555},
    {C_WIDE, 2'b00, 32'h0001_0000, 32'hFFFF_FFFF}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  half_sel = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic        done;
  logic        busy;
  logic [31:0] acc_lo;
  logic [31:0] acc_hi;

  int n_checks = 0;
  int n_errors = 0;
  logic [39:0] m_acc = '0;

  always #10 clk = ~clk;

  mac40_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .half_sel(half_sel),
    .src_a(src_a), .src_b(src_b), .done(done), .busy(busy),
    .acc_lo(acc_lo), .acc_hi(acc_hi)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] model(input logic [39:0] acc, input logic [2:0] c,
      input logic [1:0] hs, input logic [31:0] a, input logic [31:0] b);
    longint s;
    logic [15:0] x, y;
    s = longint'(acc);
    case (c)
      C_HALF: begin
        x = hs[1] ? a[31:16] : a[15:0];
        y = hs[0] ? b[31:16] : b[15:0];
        s = s + longint'($signed(x)) * longint'($signed(y));
      end
      C_DUAL: s = s + longint'($signed(a[31:16])) * longint'($signed(b[31:16]))
                    + longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
      C_WIDE: s = s + longint'($signed(a)) * longint'($signed(b));
      C_LOAD: s = {24'h0, b[7:0], a};
      default: ;
    endcase
    return s[39:0];
  endfunction

  function automatic bit slow(input logic [2:0] c, input logic [31:0] a);
    longint v;
    v = longint'($signed(a));
    return (c == C_WIDE) && (v > 32767 || v < -32768);
  endfunction

  function automatic string req_of(input logic [2:0] c);
    case (c)
      C_HALF: return "R2";
      C_DUAL: return "R4";
      C_WIDE: return "R5";
      C_LOAD: return "R9";
      C_READ: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check_acc(input string req);
    logic [31:0] ehi;
    ehi = {{24{m_acc[39]}}, m_acc[39:32]};
    chk(acc_lo == m_acc[31:0], req, 64'(acc_lo), 64'(m_acc[31:0]));
    chk(acc_hi == ehi, req, 64'(acc_hi), 64'(ehi));
  endtask

  // Drive at a falling edge; return at the falling edge after acceptance.
  task automatic run_op(input logic [2:0] c, input logic [1:0] hs,
                        input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_valid = 1'b1; op = c; half_sel = hs; src_a = a; src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    if (slow(c, a)) begin
      chk(busy && !done, "R7 first step", {62'h0, busy, done}, 64'h2);
      @(negedge clk);
      chk(done && !busy, "R7 second step", {62'h0, busy, done}, 64'h1);
    end else begin
      chk(done && !busy, "R6 single cycle", {62'h0, busy, done}, 64'h1);
    end
    m_acc = model(m_acc, c, hs, a, b);
    check_acc(req_of(c));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(acc_lo == 0 && acc_hi == 0 && !done && !busy, "R1",
        {acc_hi, acc_lo}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][68:66], VEC[i][65:64], VEC[i][63:32], VEC[i][31:0]);
    end

    // R11 idle cycle: no done, no change
    @(negedge clk);
    chk(!done, "R11 idle done", 64'(done), 64'h0);
    check_acc("R11");

    // R3 wrap at 40 bits and sign extension of the high word
    run_op(C_LOAD, 2'b00, 32'hFFFF_FFFF, 32'h0000_007F);
    run_op(C_HALF, 2'b00, 32'h0000_0001, 32'h0000_0001);
    chk(acc_hi == 32'hFFFF_FF80 && acc_lo == 32'h0, "R3 wrap",
        {acc_hi, acc_lo}, 64'hFFFF_FF80_0000_0000);
    run_op(C_LOAD, 2'b00, 32'hFFFF_FFFF, 32'h0000_00FF);
    run_op(C_HALF, 2'b00, 32'h0000_0001, 32'h0000_0001);
    chk(acc_hi == 0 && acc_lo == 0, "R3 carry out dropped",
        {acc_hi, acc_lo}, 64'h0);

    // R8 request during the busy step is ignored
    @(negedge clk);
    in_valid = 1'b1; op = C_WIDE; src_a = 32'h1234_5678; src_b = 32'h0000_0003;
    @(negedge clk);
    chk(busy, "R8 busy seen", 64'(busy), 64'h1);
    op = C_LOAD; src_a = 32'hAAAA_AAAA; src_b = 32'h0000_0055;
    @(negedge clk);
    in_valid = 1'b0;
    m_acc = model(m_acc, C_WIDE, 2'b00, 32'h1234_5678, 32'h0000_0003);
    chk(done, "R8 wide done", 64'(done), 64'h1);
    check_acc("R8");
    @(negedge clk);
    chk(!done && !busy, "R8 no extra done", {62'h0, busy, done}, 64'h0);
    check_acc("R8");

    // R1 reset in mid-run clears the sum
    run_op(C_LOAD, 2'b00, 32'h0BAD_F00D, 32'h0000_0011);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_acc = '0;
    chk(!done && !busy, "R1 mid reset flags", {62'h0, busy, done}, 64'h0);
    check_acc("R1");

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule